// File: doc/BRIEF.md
# Control Command Sub-Packet Executor

This block takes the payload of a control packet as a stream of 32-bit words, most significant byte first, and runs the command sub-packets it finds there one after another. Each sub-packet starts with a header word. The header carries an opcode and a byte count of the arguments that follow. The sub-packet is padded so that the next header always lands on a word boundary. A payload may hold no sub-packets or any number of them back to back.

The commands are:

- a register write;
- a masked register write, which changes only the bits selected by a mask;
- a register read, which returns a two-word reply on the output stream;
- a delay, which stalls the stream for a given number of clock cycles.

The register file of 256 words sits inside the block. Any other opcode is stepped over by its length.

Both streams use valid/ready. A word moves only in a cycle where valid and ready are both high. The block lowers `in_ready` while a delay is counting and while a reply is waiting to leave. A reply word stays on `out_data`, with `out_valid` high, until the sink takes it with `out_ready`.

Top module: `ctl_cmd_exec`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every register reads as zero.
- R2: The header word fields are placed as follows: bits 31:24 are the opcode, bits 23:16 the byte length, bits 15:8 the tag byte, and bits 7:0 the register number. Sub-packets follow each other with no gap, and the word after a sub-packet's last word is taken as the next header.
- R3: Opcode 0x01 with length 6 is a write. The next word is stored as the new value of the register named in the header.
- R4: Opcode 0x02 with length 10 is a masked write. It is followed by a value word and then a mask word. The register becomes (old & ~mask) | (value & mask).
- R5: Opcode 0x03 with length 2 is a read. It produces a reply of two words. The first reply word is {0x83, 0x06, tag, register number}. The second is the register value at the time the read header was accepted.
- R6: `out_data` and `out_valid` hold steady while `out_ready` is low. `in_ready` stays low from the cycle after a read header is taken until the cycle after the last reply word is taken.
- R7: Opcode 0x04 with length 2 is a delay, with an unsigned tick count N in bits 15:0. `in_ready` is low for exactly N cycles right after the header is taken. N = 0 gives no stall.
- R8: A header with an unknown opcode and length L consumes ceil((L+2)/4) words in total, counting the header. It produces no reply and changes no register.
- R9: A known opcode whose length differs from the value given in R3, R4, R5 or R7 is treated as unknown and skipped as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block accepts a command word |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Reply word present |
| out_ready | input | 1 | Sink accepts a reply word |
| out_data | output | 32 | Reply word |

## Verification
A sequencer that loses its place in a sub-packet shows up within one or two commands. The misparsed word either makes a spurious reply or swallows a later read, so the next read reply goes missing or carries the wrong header word. A corrupted register is only visible through a later read of that register, so every write is followed by a read of the same entry. A wrong delay or reply-busy state shows at once as a wrong number of stalled `in_ready` cycles.

// File: rtl/ctl_exec_pkg.sv
package ctl_exec_pkg;
  localparam int WORD_W = 32;
  localparam int SKIP_W = 7;   // up to 64 remaining words for a length of 255

  localparam logic [7:0] OP_WRITE  = 8'h01;
  localparam logic [7:0] OP_MWRITE = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_DELAY  = 8'h04;
  localparam logic [7:0] OP_REPLY  = 8'h83;

  localparam logic [7:0] LEN_WRITE  = 8'd6;
  localparam logic [7:0] LEN_MWRITE = 8'd10;
  localparam logic [7:0] LEN_READ   = 8'd2;
  localparam logic [7:0] LEN_DELAY  = 8'd2;
  localparam logic [7:0] LEN_REPLY  = 8'd6;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_VAL,
    ST_MASK,
    ST_SKIP
  } seq_st_e;
endpackage

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int NREGS = 256,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [AW-1:0]                     waddr,
  input  logic [ctl_exec_pkg::WORD_W-1:0]   wdata,
  input  logic [ctl_exec_pkg::WORD_W-1:0]   wmask,
  input  logic [AW-1:0]                     raddr,
  output logic [ctl_exec_pkg::WORD_W-1:0]   rdata
);
  import ctl_exec_pkg::*;

  logic [WORD_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end
  end

  assign rdata = mem[raddr];

  // R3: a full-mask write leaves exactly the written word in the entry
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (&wmask)) |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/ctl_tick_timer.sv
module ctl_tick_timer #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] ticks,
  output logic              busy
);
  logic [TICK_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= ticks;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R7: a loaded count of zero never produces a stall
  a_r7_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ticks == '0) |=> !busy);
endmodule

// File: rtl/ctl_reply_tx.sv
module ctl_reply_tx (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [ctl_exec_pkg::WORD_W-1:0]  w0,
  input  logic [ctl_exec_pkg::WORD_W-1:0]  w1,
  output logic                             busy,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [ctl_exec_pkg::WORD_W-1:0]  out_data
);
  import ctl_exec_pkg::*;

  logic [WORD_W-1:0] w0_q, w1_q;
  logic              beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= 1'b0;
      w0_q <= '0;
      w1_q <= '0;
    end else if (load) begin
      busy <= 1'b1;
      beat <= 1'b0;
      w0_q <= w0;
      w1_q <= w1;
    end else if (busy && out_ready) begin
      if (!beat) beat <= 1'b1;
      else       busy <= 1'b0;
    end
  end

  assign out_valid = busy;
  assign out_data  = beat ? w1_q : w0_q;

  // R6: an offered word is held until it is taken
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R5: the first reply word is always followed by a second one
  a_r5_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !beat) |=> out_valid);
endmodule

// File: rtl/ctl_cmd_seq.sv
module ctl_cmd_seq #(
  parameter int AW     = 8,
  parameter int TICK_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_fire,
  input  logic [ctl_exec_pkg::WORD_W-1:0]  in_data,
  output logic                             wr_en,
  output logic [AW-1:0]                    wr_addr,
  output logic [ctl_exec_pkg::WORD_W-1:0]  wr_data,
  output logic [ctl_exec_pkg::WORD_W-1:0]  wr_mask,
  output logic [AW-1:0]                    rd_addr,
  input  logic [ctl_exec_pkg::WORD_W-1:0]  rd_data,
  output logic                             rep_load,
  output logic [ctl_exec_pkg::WORD_W-1:0]  rep_w0,
  output logic [ctl_exec_pkg::WORD_W-1:0]  rep_w1,
  output logic                             tmr_load,
  output logic [TICK_W-1:0]                tmr_ticks
);
  import ctl_exec_pkg::*;

  seq_st_e           st;
  logic              masked;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] val_q;
  logic [SKIP_W-1:0] skip_cnt;

  logic [7:0] h_op, h_len;
  logic       hdr_fire, is_wr, is_mwr, is_rd, is_dly;
  logic [8:0] words_all;

  assign h_op   = in_data[31:24];
  assign h_len  = in_data[23:16];
  assign hdr_fire = in_fire && (st == ST_HDR);
  assign is_wr  = (h_op == OP_WRITE)  && (h_len == LEN_WRITE);
  assign is_mwr = (h_op == OP_MWRITE) && (h_len == LEN_MWRITE);
  assign is_rd  = (h_op == OP_READ)   && (h_len == LEN_READ);
  assign is_dly = (h_op == OP_DELAY)  && (h_len == LEN_DELAY);
  // ceil((len + 2) / 4) words including the header
  assign words_all = ({1'b0, h_len} + 9'd5) >> 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HDR;
      masked   <= 1'b0;
      addr_q   <= '0;
      val_q    <= '0;
      skip_cnt <= '0;
    end else if (in_fire) begin
      unique case (st)
        ST_HDR: begin
          if (is_wr || is_mwr) begin
            st     <= ST_VAL;
            masked <= is_mwr;
            addr_q <= in_data[AW-1:0];
          end else if (!is_rd && !is_dly && words_all > 9'd1) begin
            st       <= ST_SKIP;
            skip_cnt <= SKIP_W'(words_all - 9'd1);
          end
        end
        ST_VAL: begin
          val_q <= in_data;
          st    <= masked ? ST_MASK : ST_HDR;
        end
        ST_MASK: st <= ST_HDR;
        ST_SKIP: begin
          skip_cnt <= skip_cnt - 1'b1;
          if (skip_cnt == SKIP_W'(1)) st <= ST_HDR;
        end
        default: st <= ST_HDR;
      endcase
    end
  end

  assign wr_en   = in_fire && (((st == ST_VAL) && !masked) || (st == ST_MASK));
  assign wr_addr = addr_q;
  assign wr_data = (st == ST_MASK) ? val_q : in_data;
  assign wr_mask = (st == ST_MASK) ? in_data : '1;

  assign rd_addr  = in_data[AW-1:0];
  assign rep_load = hdr_fire && is_rd;
  assign rep_w0   = {OP_REPLY, LEN_REPLY, in_data[15:8], in_data[7:0]};
  assign rep_w1   = rd_data;

  assign tmr_load  = hdr_fire && is_dly;
  assign tmr_ticks = in_data[TICK_W-1:0];

  // R8: the skip state is only entered with words still to drop
  a_r8_skip_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> (skip_cnt != '0));
  // R4: the mask word is reached only through the value word
  a_r4_mask_after_value: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MASK) |-> ($past(st) == ST_VAL || $past(st) == ST_MASK));
endmodule

// File: rtl/ctl_cmd_exec.sv
module ctl_cmd_exec #(
  parameter int NREGS  = 256,
  parameter int TICK_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);
  import ctl_exec_pkg::*;

  localparam int AW = $clog2(NREGS);

  logic              in_fire, tmr_busy, rep_busy;
  logic              wr_en, rep_load, tmr_load;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_data, wr_mask, rd_data, rep_w0, rep_w1;
  logic [TICK_W-1:0] tmr_ticks;

  assign in_ready = !tmr_busy && !rep_busy;
  assign in_fire  = in_valid && in_ready;

  ctl_cmd_seq #(.AW(AW), .TICK_W(TICK_W)) u_seq (
    .clk, .rst_n, .in_fire, .in_data,
    .wr_en, .wr_addr, .wr_data, .wr_mask,
    .rd_addr, .rd_data,
    .rep_load, .rep_w0, .rep_w1,
    .tmr_load, .tmr_ticks
  );

  ctl_reg_bank #(.NREGS(NREGS), .AW(AW)) u_regs (
    .clk, .rst_n, .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .wmask(wr_mask), .raddr(rd_addr), .rdata(rd_data)
  );

  ctl_tick_timer #(.TICK_W(TICK_W)) u_tmr (
    .clk, .rst_n, .load(tmr_load), .ticks(tmr_ticks), .busy(tmr_busy)
  );

  ctl_reply_tx u_rep (
    .clk, .rst_n, .load(rep_load), .w0(rep_w0), .w1(rep_w1),
    .busy(rep_busy), .out_valid, .out_ready, .out_data
  );

  // R7: a stall and a pending reply never overlap
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_busy && rep_busy));
  // R6: a reply starts only after a command word was taken
  a_r6_reply_after_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_fire));
endmodule

// File: tb/ctl_cmd_exec_test.sv
`timescale 1ns/1ps
module ctl_cmd_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rep [0:255];
  int rcnt = 0;

  always #10 clk = ~clk;   // 50 MHz

  ctl_cmd_exec uut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rcnt < 256) begin
      rep[rcnt] = out_data;
      rcnt = rcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_replies(input int target);
    for (int i = 0; i < 60 && rcnt < target; i++) @(negedge clk);
  endtask

  task automatic rd_check(input logic [7:0] tag_b, input logic [7:0] rg, input logic [31:0] exp, input string req);
    int base;
    base = rcnt;
    put({8'h03, 8'h02, tag_b, rg});
    wait_replies(base + 2);
    chk(rcnt == base + 2, {req, " reply count"}, rcnt - base, 2);
    chk(rep[base] == {8'h83, 8'h06, tag_b, rg}, {req, " reply header (R5)"}, rep[base], {8'h83, 8'h06, tag_b, rg});
    chk(rep[base+1] == exp, {req, " register value"}, rep[base+1], exp);
  endtask

  task automatic t_reset;
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    rd_check(8'h01, 8'h10, 32'h0, "R1 reg 0x10");
    rd_check(8'h02, 8'hFF, 32'h0, "R1 reg 0xFF");
  endtask

  task automatic t_write;
    put(32'h0106_0005);
    put(32'hDEAD_BEEF);
    rd_check(8'h3C, 8'h05, 32'hDEAD_BEEF, "R3 write");
    rd_check(8'h3D, 8'h04, 32'h0, "R3 neighbour untouched");
  endtask

  task automatic t_masked;
    put(32'h0106_0007);
    put(32'hF0F0_F0F0);
    put(32'h020A_0007);
    put(32'h1234_5678);
    put(32'h0000_FFFF);
    rd_check(8'h40, 8'h07, 32'hF0F0_5678, "R4 masked write");
  endtask

  task automatic t_back_to_back;
    int base;
    base = rcnt;
    put(32'h0106_0021); put(32'h1111_1111);
    put(32'h0106_0022); put(32'h2222_2222);
    put(32'h0302_5521);
    put(32'h0302_5622);
    wait_replies(base + 4);
    chk(rcnt == base + 4, "R2 reply count", rcnt - base, 4);
    chk(rep[base+1] == 32'h1111_1111, "R2 first read", rep[base+1], 32'h1111_1111);
    chk(rep[base+2] == 32'h8306_5622, "R2 second header", rep[base+2], 32'h8306_5622);
    chk(rep[base+3] == 32'h2222_2222, "R2 second read", rep[base+3], 32'h2222_2222);
  endtask

  task automatic t_backpressure;
    int base;
    bit held;
    base = rcnt;
    @(posedge clk); #1 out_ready = 1'b0;
    put(32'h0302_7705);
    held = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!(out_valid && out_data == 32'h8306_7705 && !in_ready)) held = 1'b0;
    end
    chk(held, "R6 reply held under backpressure", {out_valid, in_ready}, 32'h2);
    @(posedge clk); #1 out_ready = 1'b1;
    wait_replies(base + 2);
    chk(rep[base+1] == 32'hDEAD_BEEF, "R6 value after release", rep[base+1], 32'hDEAD_BEEF);
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 in_ready back after reply", in_ready, 1);
  endtask

  task automatic t_delay(input logic [15:0] n);
    int lows;
    lows = 0;
    put({8'h04, 8'h02, n});
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!in_ready) lows++;
      else break;
    end
    chk(lows == int'(n), "R7 stall cycles", lows, n);
  endtask

  task automatic t_skip;
    int base;
    base = rcnt;
    put(32'h5505_0000);            // 2 words total
    put(32'h0106_00AA);            // filler that looks like a write
    put(32'h7700_0000);            // length 0: header only
    put(32'h66FF_0000);            // length 255: 65 words total
    for (int i = 0; i < 64; i++) put(32'h0302_0000);
    repeat (4) @(negedge clk);
    chk(rcnt == base, "R8 no reply from skipped words", rcnt - base, 0);
    rd_check(8'h51, 8'hAA, 32'h0, "R8 skipped write left reg");
  endtask

  task automatic t_badlen;
    int base;
    base = rcnt;
    put(32'h0102_00AB);            // write with length 2: one word
    put(32'h0303_61AB);            // read with length 3: two words
    put(32'h0302_62AB);            // filler looks like a read
    repeat (4) @(negedge clk);
    chk(rcnt == base, "R9 no reply from bad-length commands", rcnt - base, 0);
    rd_check(8'h63, 8'hAB, 32'h0, "R9 bad-length write ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write;
    t_masked;
    t_back_to_back;
    t_backpressure;
    t_delay(16'd7);
    t_delay(16'd0);
    t_delay(16'd1);
    t_skip;
    t_badlen;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule